// File: doc/BRIEF.md
# Redundant-Accumulator Modular Multiplier

This block computes the product of two unsigned operands modulo a constant `M` that is fixed when the design is elaborated. It walks the multiplier operand `X` one bit per cycle, starting at the most significant bit. Each cycle it doubles a running accumulator and adds either `Y` or zero. The accumulator is held in a redundant form: a sum vector split into digits, plus a small carry field at each digit boundary. As a result no step has a carry chain longer than one digit.

The modulus is not folded in with comparisons. The four top bits of the accumulator's sum vector select an entry in a 16-entry table of residues, and that table is computed from `M` at elaboration. The loop ends with one extra step in which the multiplier bit is forced to zero, which makes the accumulator even. The block then turns the redundant value into binary in one cycle. It halves that value by dropping bit 0 and applies a single conditional subtraction of `M`.

Operands enter over a valid/ready pair. `in_ready` is high only while the block is idle. A request is taken on a cycle where `in_valid` and `in_ready` are both high. A request while busy is simply not taken, and the caller has to hold it until `in_ready` returns. The result leaves on a one-cycle `out_valid` pulse with no back-pressure. `out_prod` keeps its value until the next result.

Top module: `hrcs_modmul`

## Requirements
- R1: While reset is asserted and after it is released, `out_valid` is 0, `in_ready` is 1 and `out_prod` is 0.
- R2: `in_ready` is 1 exactly when no operation is in progress. A request is accepted on a rising edge where `in_valid` and `in_ready` are both 1, and `in_ready` is 0 on the following cycle.
- R3: `in_valid` asserted while `in_ready` is 0 has no effect: the running operation's result is unchanged and no additional `out_valid` pulse follows.
- R4: `out_valid` rises R+3 cycles after the accepting edge (R bit steps, one zero step, one conversion cycle, one correction cycle) and stays high for exactly one cycle.
- R5: With `out_valid` high, `out_prod` equals (X·Y) mod M and is below M, for every R-bit X and every Y in 0..M-1.
- R6: `out_prod` does not change on any cycle where `out_valid` is 0.
- R7: The sum vector is N+2 bits wide, and the top digit of each step never produces a carry out.
- R8: The residue table is indexed by bits N+1..N-2 of the sum vector (value k in 0..15), and entry k holds (k·2^(N-2)) mod M.
- R9: After the zero step the converted value is even, and half of it is below 2M.
- R10: X = 0 or Y = 0 gives 0; X with all bits set together with Y = M-1 gives the exact residue.
- R11: Digit width DW of at least 3 is accepted. The top digit takes the remaining bits and is at least 6 bits wide, which keeps all boundary carries below bit N-2.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | Operand request |
| in_ready | output | 1 | Block idle; request is taken this cycle |
| in_x | input | R | Multiplier operand X |
| in_y | input | N | Multiplicand Y, must be below M |
| out_valid | output | 1 | One-cycle result strobe |
| out_prod | output | N | (X·Y) mod M, held until the next result |

## Verification
The assertions check the following on every clock: the top digit never carries out, the converted value is even and its half is below 2M, the result is below M, the output is stable between strobes, the strobe lasts one cycle, and a request is never taken while busy. Only the bench's scenarios can show that the residue is numerically correct, including the table contents and the redundant arithmetic. Those scenarios also show the exact R+3 latency and that an ignored request leaves the running result untouched. The sweep covers every X for a set of Y values on two moduli: one just above 2^(N-1), where the final halving has the least slack, and one near 2^N.

// File: rtl/hrcs_pkg.sv
package hrcs_pkg;

  // bits of the sum vector that address the residue table
  localparam int unsigned KB = 4;

  typedef enum logic [1:0] {
    ST_IDLE,
    ST_RUN,
    ST_CONV,
    ST_CORR
  } hrcs_state_e;

  // number of digits: all but the top one are dw bits wide, the top one
  // keeps at least 6 bits so that boundary carries stay below bit n-2
  function automatic int unsigned digit_count(input int unsigned n, input int unsigned dw);
    return ((n + 2 - 6) / dw) + 1;
  endfunction

  function automatic int unsigned top_width(input int unsigned n, input int unsigned dw);
    return (n + 2) - (digit_count(n, dw) - 1) * dw;
  endfunction

endpackage

// File: rtl/hrcs_tbl.sv
module hrcs_tbl
  import hrcs_pkg::*;
#(
  parameter int unsigned N   = 16,
  parameter logic [N-1:0] MOD = 16'hFFF1
) (
  input  logic [KB-1:0] k,
  output logic [N-1:0]  res
);
  localparam int unsigned S    = N - 2;
  localparam int unsigned ENT  = 1 << KB;
  localparam logic [N+4:0] MEXT = {5'b0, MOD};

  logic [N-1:0] rom [ENT];

  // entry e = (e * 2^S) mod M, folded at elaboration (R8)
  for (genvar e = 0; e < ENT; e++) begin : g_ent
    localparam logic [N+4:0] RAW = ((N+5)'(e) << S) % MEXT;
    assign rom[e] = RAW[N-1:0];
  end

  assign res = rom[k];

endmodule

// File: rtl/hrcs_digit.sv
module hrcs_digit #(
  parameter int unsigned WD = 4
) (
  input  logic [WD-1:0] a,
  input  logic [WD-1:0] b,
  input  logic [WD-1:0] c,
  input  logic [WD-1:0] d,
  output logic [WD-1:0] sum,
  output logic [1:0]    cout
);
  logic [WD+1:0] tot;

  // four-operand ripple add confined to one digit
  always_comb begin
    tot  = {2'b0, a} + {2'b0, b} + {2'b0, c} + {2'b0, d};
    sum  = tot[WD-1:0];
    cout = tot[WD+1:WD];
  end

endmodule

// File: rtl/hrcs_step.sv
module hrcs_step
  import hrcs_pkg::*;
#(
  parameter int unsigned N   = 16,
  parameter int unsigned DW  = 4,
  parameter logic [N-1:0] MOD = 16'hFFF1
) (
  input  logic [N+1:0] ps,
  input  logic [N+1:0] cv,
  input  logic         xbit,
  input  logic [N-1:0] y,
  output logic [N+1:0] ps_nxt,
  output logic [N+1:0] cv_nxt,
  output logic [1:0]   top_carry
);
  localparam int unsigned WS = N + 2;
  localparam int unsigned S  = N - 2;
  localparam int unsigned ND = digit_count(N, DW);
  localparam int unsigned WT = top_width(N, DW);

  logic [KB-1:0] k;
  logic [S-1:0]  low;
  logic [N-1:0]  tab;
  logic [WS-1:0] op_y, op_t, op_l, op_c;
  logic [1:0]    cy [ND];

  assign k   = ps[WS-1:S];
  assign low = ps[S-1:0];

  hrcs_tbl #(.N(N), .MOD(MOD)) u_tbl (
    .k   (k),
    .res (tab)
  );

  // value: x*Y + 2*table[k] + 2*low + 2*carries, congruent to 2P + x*Y
  always_comb begin
    op_y = {2'b00, (xbit ? y : '0)};
    op_t = {1'b0, tab, 1'b0};
    op_l = {{(WS-S-1){1'b0}}, low, 1'b0};
    op_c = cv << 1;
  end

  for (genvar j = 0; j < ND; j++) begin : g_dig
    localparam int unsigned LO = j * DW;
    localparam int unsigned WD = (j == ND - 1) ? WT : DW;
    hrcs_digit #(.WD(WD)) u_dig (
      .a    (op_y[LO +: WD]),
      .b    (op_t[LO +: WD]),
      .c    (op_l[LO +: WD]),
      .d    (op_c[LO +: WD]),
      .sum  (ps_nxt[LO +: WD]),
      .cout (cy[j])
    );
  end

  always_comb begin
    cv_nxt = '0;
    for (int j = 1; j < ND; j++) begin
      cv_nxt[j*DW +: 2] = cy[j-1];
    end
  end

  assign top_carry = cy[ND-1];

endmodule

// File: rtl/hrcs_modmul.sv
module hrcs_modmul
  import hrcs_pkg::*;
#(
  parameter int unsigned N   = 16,
  parameter int unsigned R   = 16,
  parameter int unsigned DW  = 4,
  parameter logic [N-1:0] MOD = 16'hFFF1
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         in_valid,
  output logic         in_ready,
  input  logic [R-1:0] in_x,
  input  logic [N-1:0] in_y,
  output logic         out_valid,
  output logic [N-1:0] out_prod
);
  localparam int unsigned WS = N + 2;
  localparam int unsigned CW = $clog2(R + 2);

  hrcs_state_e   state;
  logic [CW-1:0] cnt;
  logic [R-1:0]  xr;
  logic [N-1:0]  yr;
  logic [WS-1:0] ps, cv, ps_nxt, cv_nxt;
  logic [1:0]    top_carry;
  logic [WS:0]   vsum;
  logic [WS-1:0] half;
  logic [WS-1:0] two_m;
  logic          take;

  assign in_ready = (state == ST_IDLE);
  assign take     = in_valid && in_ready;
  assign half     = vsum[WS:1];
  assign two_m    = {1'b0, MOD, 1'b0};

  hrcs_step #(.N(N), .DW(DW), .MOD(MOD)) u_step (
    .ps        (ps),
    .cv        (cv),
    .xbit      (xr[R-1]),
    .y         (yr),
    .ps_nxt    (ps_nxt),
    .cv_nxt    (cv_nxt),
    .top_carry (top_carry)
  );

  // control, redundant accumulator, conversion and correction
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state     <= ST_IDLE;
      cnt       <= '0;
      xr        <= '0;
      yr        <= '0;
      ps        <= '0;
      cv        <= '0;
      vsum      <= '0;
      out_valid <= 1'b0;
      out_prod  <= '0;
    end else begin
      out_valid <= 1'b0;
      case (state)
        ST_IDLE: begin
          if (take) begin
            xr    <= in_x;
            yr    <= in_y;
            ps    <= '0;
            cv    <= '0;
            cnt   <= CW'(R);
            state <= ST_RUN;
          end
        end
        ST_RUN: begin
          // shifting in zeros makes the last of R+1 steps the zero step
          ps <= ps_nxt;
          cv <= cv_nxt;
          xr <= xr << 1;
          if (cnt == '0) state <= ST_CONV;
          else           cnt   <= cnt - 1'b1;
        end
        ST_CONV: begin
          vsum  <= {1'b0, ps} + {1'b0, cv};
          state <= ST_CORR;
        end
        ST_CORR: begin
          if (half >= {2'b00, MOD}) out_prod <= N'(half - {2'b00, MOD});
          else                      out_prod <= half[N-1:0];
          out_valid <= 1'b1;
          state     <= ST_IDLE;
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  // R7: the top digit never carries out of the N+2-bit sum vector
  p_top_no_carry_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_RUN) |-> (top_carry == 2'b00));

  // R9: converted value is even and its half lies below 2M
  p_half_bound_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_CORR) |-> (!vsum[0] && (half < two_m)));

  // R5: a delivered result is fully reduced
  p_reduced_r5: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> (out_prod < MOD));

  // R4: the result strobe lasts one cycle
  p_strobe_one_r4: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |=> !out_valid);

  // R6: result held between strobes
  p_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !out_valid |-> $stable(out_prod));

  // R2: an accepted request makes the block busy next cycle
  p_busy_after_take_r2: assert property (@(posedge clk) disable iff (!rst_n)
    take |=> !in_ready);

  // R3: a request while busy leaves the latched operand untouched
  p_busy_ignore_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && !in_ready) |=> $stable(yr));

endmodule

// File: tb/test_hrcs_modmul.sv
module test_hrcs_modmul;
  localparam int unsigned N  = 8;
  localparam int unsigned R  = 8;
  localparam int unsigned DW = 3;
  localparam int unsigned MA = 129;
  localparam int unsigned MB = 251;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         in_valid = 1'b0;
  logic [R-1:0] in_x = '0;
  logic [N-1:0] in_ya = '0, in_yb = '0;
  logic         rdy_a, rdy_b, ov_a, ov_b;
  logic [N-1:0] pa, pb;

  int checks = 0;
  int errors = 0;
  bit finished = 1'b0;

  always #4 clk = ~clk;

  hrcs_modmul #(.N(N), .R(R), .DW(DW), .MOD(8'(MA))) i_hrcs_modmul (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(rdy_a),
    .in_x(in_x), .in_y(in_ya), .out_valid(ov_a), .out_prod(pa));

  hrcs_modmul #(.N(N), .R(R), .DW(DW), .MOD(8'(MB))) i_hrcs_modmul_b (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(rdy_b),
    .in_x(in_x), .in_y(in_yb), .out_valid(ov_b), .out_prod(pb));

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual %0d expected %0d", tag, act, exp);
    end
  endtask

  // one operation on both instances; optional request injected while busy
  task automatic run_op(input int x, input int ya, input int yb, input bit inject);
    int ea, eb;
    ea = (x * ya) % MA;
    eb = (x * yb) % MB;
    @(negedge clk);
    chk(rdy_a && rdy_b, "R2 ready when idle", int'(rdy_a), 1);
    in_valid = 1'b1;
    in_x = R'(x); in_ya = N'(ya); in_yb = N'(yb);
    @(negedge clk);
    in_valid = 1'b0;
    chk(!rdy_a && !rdy_b, "R2 busy after accept", int'(rdy_a), 0);
    for (int c = 1; c <= R + 3; c++) begin
      @(negedge clk);
      if (inject && c == 3) begin
        chk(!rdy_a, "R3 not ready while busy", int'(rdy_a), 0);
        in_valid = 1'b1;
        in_x = ~R'(x); in_ya = N'((ya + 5) % MA); in_yb = N'((yb + 7) % MB);
      end
      if (inject && c == 4) in_valid = 1'b0;
      if (c < R + 3)
        chk(!ov_a && !ov_b, "R4 no early strobe", int'(ov_a), 0);
      else
        chk(ov_a && ov_b, "R4 strobe at R+3", int'(ov_a), 1);
    end
    // R5 R7 R8 R9 R10: residue matches X*Y mod M
    chk(int'(pa) == ea, "R5 R7 R8 R9 result (M low)", int'(pa), ea);
    chk(int'(pb) == eb, "R5 R7 R8 R9 result (M high)", int'(pb), eb);
    @(negedge clk);
    chk(!ov_a && !ov_b, "R4 strobe one cycle", int'(ov_a), 0);
    chk(int'(pa) == ea && int'(pb) == eb, "R6 result held", int'(pa), ea);
    if (inject) begin
      for (int c = 0; c < R + 5; c++) begin
        @(negedge clk);
        chk(!ov_a && !ov_b, "R3 no strobe from ignored request", int'(ov_a), 0);
      end
      chk(int'(pa) == ea && int'(pb) == eb, "R3 result unchanged", int'(pa), ea);
    end
  endtask

  initial begin
    int ya_set [6] = '{0, 1, 2, 64, 100, 128};
    int yb_set [6] = '{0, 1, 250, 125, 200, 250};
    repeat (3) @(negedge clk);
    chk(!ov_a && !ov_b && rdy_a && rdy_b && pa == 0 && pb == 0,
        "R1 state in reset", int'(pa), 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk(!ov_a && rdy_a && pa == 0, "R1 state after reset", int'(pa), 0);
    // R10 corners
    run_op(0, 128, 250, 1'b0);
    chk(pa == 0 && pb == 0, "R10 X zero", int'(pb), 0);
    run_op(255, 0, 0, 1'b0);
    chk(pa == 0 && pb == 0, "R10 Y zero", int'(pb), 0);
    run_op(255, MA - 1, MB - 1, 1'b0);
    chk(int'(pa) == (255 * (MA - 1)) % MA, "R10 all ones, M-1", int'(pa), (255 * (MA - 1)) % MA);
    // R3 request while busy
    run_op(173, 77, 222, 1'b1);
    // R11 sweep of every X over a set of Y (DW=3, top digit 7 bits)
    for (int yi = 0; yi < 6; yi++)
      for (int x = 0; x < 256; x++)
        run_op(x, ya_set[yi], yb_set[yi], 1'b0);
    finished = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    #(8 * 190000);
    if (!finished) begin
      checks++;
      errors++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

endmodule